// File: doc/BRIEF.md
# Pulse-Disciplined Nanosecond Time Counter

This block keeps a 48-bit time value from a fast local clock and steers it with a once-per-second reference pulse from a satellite receiver. The low 30 bits count nanoseconds within the current second. Each cycle a fixed-point step with 32 fractional bits is added to an accumulator. That step is recomputed from the number of local cycles measured between accepted reference pulses, so the nanosecond count changes rate smoothly and never jumps. On an accepted pulse edge the nanosecond field returns to zero. The high 18 bits hold the second of the day. A companion parser delivers a second-of-day value, and that value is taken over exactly at the next accepted pulse.

Pulse edges are filtered so that glitches and spurious extra edges do not disturb the count. Without a reference the counter keeps running at its last rate and rolls over by itself. A mode input selects between this format and a legacy free-running count at a slower nominal rate. A frame-end strobe freezes the current output for the frame that has just ended. A signed lock offset reports how far the count was from a full second when each pulse was accepted.

Top module: `gps_time_stamper`

## Requirements
- R1: While reset is asserted and after it is released, `ts_o`, `stamp_o`, `stamp_vld_o` and `lock_off_o` read zero until the first clock edge that changes them. The step starts at floor(1e9·2^32 / CLK_HZ).
- R2: The accumulator is {nanoseconds[29:0], fraction[31:0]}. It grows by the current step on every clock on which no pulse is accepted.
- R3: A pulse accepted while a reference is held measures the period P in cycles since the previous accepted edge. The new step floor(1e9·2^32 / P) is loaded 62 clocks after the accepting clock. The first addition that uses it is on the clock after that.
- R4: `pps_i` is synchronized by two flops, and a rising edge acts two clocks after it is first sampled high. An edge is accepted when no reference is held, or when the period count lies within CLK_HZ ± CLK_HZ/TOL_DIV. Any other edge changes no output.
- R5: On an accepted edge the accumulator clears to zero. The seconds field then takes the pending second-of-day if one is pending. Otherwise it advances by one when the nanoseconds were at least 500,000,000, and holds when they were below that (the counter had already rolled over). A second-of-day value of 86400 or more is ignored.
- R6: Without an accepted edge, an accumulator that reaches 1e9·2^32 drops by that amount, and the seconds field advances in the same clock.
- R7: The seconds field advances from 86399 to 0.
- R8: With `gps_mode_i` = 1, `ts_o` = {seconds[17:0], nanoseconds[29:0]}. With `gps_mode_i` = 0, `ts_o` is the legacy count, equal to floor(k·LEG_HZ / CLK_HZ) after k clocks since reset.
- R9: A clock with `frame_end_i` high loads `stamp_o` with that cycle's `ts_o` and raises `stamp_vld_o` for exactly the following cycle.
- R10: On each accepted edge, `lock_off_o` becomes nanoseconds − 1e9 (two's complement) if the nanoseconds were at least 500,000,000, and the nanoseconds otherwise. It holds between accepted edges.
- R11: Once the period count passes CLK_HZ + CLK_HZ/TOL_DIV, the reference is dropped. The next edge is accepted for alignment only and does not change the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | Asynchronous once-per-second reference pulse |
| gps_mode_i | input | 1 | 1 selects the disciplined format, 0 the legacy count |
| tod_valid_i | input | 1 | One-cycle strobe: `tod_sec_i` holds the second for the next pulse |
| tod_sec_i | input | 18 | Second of day, counted from midnight UTC |
| frame_end_i | input | 1 | Frame-end strobe that captures the time |
| ts_o | output | 48 | Live time value in the selected format |
| stamp_o | output | 48 | Time captured at the last frame end |
| stamp_vld_o | output | 1 | High for one cycle after a capture |
| lock_off_o | output | 32 | Signed count error at the last accepted pulse |

## Verification
An edge on `pps_i` driven before clock n is acted on at clock n+2. A rate measured there is loaded at clock n+64 and first added at clock n+65. A frame-end capture and a second-of-day load are visible one clock after their strobe. The legacy count moves on the clock it is due. The reference model in the bench steps once per rising edge with these same delays. It does not copy the design's structure, and every output is compared at the falling edge that follows. Inputs change 2 ns after a rising edge, so neither model nor design sees a change in the same edge.

// File: rtl/gts_pkg.sv
package gts_pkg;
   localparam int NS_W   = 30;
   localparam int SOD_W  = 18;
   localparam int FRAC_W = 32;
   localparam int TS_W   = NS_W + SOD_W;
   localparam int ACC_W  = NS_W + FRAC_W;
   localparam int OFF_W  = 32;
   localparam int SOD_PER_DAY = 86400;
   localparam logic [63:0] NS_PER_S = 64'd1_000_000_000;
   localparam logic [ACC_W-1:0] ACC_WRAP = ACC_W'(NS_PER_S << FRAC_W);
   localparam logic [NS_W-1:0]  NS_HALF  = NS_W'(500_000_000);

   typedef logic [NS_W-1:0]  ns_t;
   typedef logic [SOD_W-1:0] sod_t;
   typedef logic [ACC_W-1:0] acc_t;
endpackage

// File: rtl/gts_pps_gate.sv
module gts_pps_gate #(
   parameter int CNT_W = 27,
   parameter int LO    = 63_936_000,
   parameter int HI    = 64_064_000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pps_i,
   output logic             accept_o,
   output logic             measure_o,
   output logic [CNT_W-1:0] period_o
);
   logic [2:0]       sync_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ref_q;
   logic             rise_w, in_win_w;

   assign rise_w    = sync_q[1] & ~sync_q[2];
   assign in_win_w  = (cnt_q >= CNT_W'(LO)) && (cnt_q <= CNT_W'(HI));
   assign accept_o  = rise_w && (!ref_q || in_win_w);
   assign measure_o = accept_o && ref_q;
   assign period_o  = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         cnt_q  <= '0;
         ref_q  <= 1'b0;
      end else begin
         sync_q <= {sync_q[1:0], pps_i};
         if (accept_o) begin
            cnt_q <= CNT_W'(1);
            ref_q <= 1'b1;
         end else begin
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            if (cnt_q > CNT_W'(HI)) ref_q <= 1'b0;
         end
      end
   end

   // R4: a measured period always lies inside the window
   p_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      measure_o |-> (period_o >= CNT_W'(LO) && period_o <= CNT_W'(HI)));
   // R11: an overlong gap drops the reference
   p_ref_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!accept_o && cnt_q > CNT_W'(HI)) |=> !measure_o);
endmodule

// File: rtl/gts_step_div.sv
module gts_step_div #(
   parameter int              DEN_W = 27,
   parameter int              Q_W   = 62,
   parameter logic [Q_W-1:0]  NUM   = '1,
   parameter logic [Q_W-1:0]  INIT  = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             busy_o,
   output logic [Q_W-1:0]   step_o
);
   localparam int IDX_W = $clog2(Q_W);

   logic [DEN_W-1:0] den_q, rem_q, rem_nx;
   logic [Q_W-1:0]   quo_q, quo_nx;
   logic [IDX_W-1:0] idx_q;
   logic [DEN_W:0]   trial_w;
   logic             ge_w;

   assign trial_w = {rem_q, NUM[idx_q]};
   assign ge_w    = trial_w >= {1'b0, den_q};
   assign rem_nx  = ge_w ? DEN_W'(trial_w - {1'b0, den_q}) : DEN_W'(trial_w);
   assign quo_nx  = {quo_q[Q_W-2:0], ge_w};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         den_q  <= '0;
         rem_q  <= '0;
         quo_q  <= '0;
         idx_q  <= '0;
         busy_o <= 1'b0;
         step_o <= INIT;
      end else if (start_i) begin
         den_q  <= den_i;
         rem_q  <= '0;
         quo_q  <= '0;
         idx_q  <= IDX_W'(Q_W-1);
         busy_o <= 1'b1;
      end else if (busy_o) begin
         rem_q <= rem_nx;
         quo_q <= quo_nx;
         if (idx_q == '0) begin
            busy_o <= 1'b0;
            step_o <= quo_nx;
         end else begin
            idx_q <= idx_q - 1'b1;
         end
      end
   end

   // R3: a new measurement never lands on a running division
   p_no_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> !busy_o);
   // R3: the step only changes as a division finishes
   p_step_on_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |=> $stable(step_o));
endmodule

// File: rtl/gts_ns_core.sv
module gts_ns_core
   import gts_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              accept_i,
   input  acc_t              step_i,
   input  logic              tod_valid_i,
   input  sod_t              tod_sec_i,
   output ns_t               ns_o,
   output sod_t              sec_o,
   output logic [OFF_W-1:0]  lock_off_o
);
   acc_t             acc_q, acc_nx;
   logic [ACC_W:0]   sum_w;
   logic             wrap_w, late_w;
   sod_t             sec_q, sec_inc_w, pend_q;
   logic             pend_v_q;
   logic [OFF_W-1:0] off_nx;

   assign ns_o      = acc_q[ACC_W-1:FRAC_W];
   assign sec_o     = sec_q;
   assign sum_w     = {1'b0, acc_q} + {1'b0, step_i};
   assign wrap_w    = sum_w >= {1'b0, ACC_WRAP};
   assign acc_nx    = wrap_w ? ACC_W'(sum_w - {1'b0, ACC_WRAP}) : ACC_W'(sum_w);
   assign late_w    = ns_o >= NS_HALF;
   assign sec_inc_w = (sec_q == SOD_W'(SOD_PER_DAY-1)) ? '0 : sec_q + 1'b1;
   assign off_nx    = late_w ? (OFF_W'(ns_o) - OFF_W'(NS_PER_S)) : OFF_W'(ns_o);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q      <= '0;
         sec_q      <= '0;
         pend_q     <= '0;
         pend_v_q   <= 1'b0;
         lock_off_o <= '0;
      end else begin
         if (accept_i) begin
            acc_q      <= '0;
            lock_off_o <= off_nx;
            pend_v_q   <= 1'b0;
            if (pend_v_q)    sec_q <= pend_q;
            else if (late_w) sec_q <= sec_inc_w;
         end else begin
            acc_q <= acc_nx;
            if (wrap_w) sec_q <= sec_inc_w;
         end
         if (tod_valid_i && tod_sec_i < SOD_W'(SOD_PER_DAY)) begin
            pend_q   <= tod_sec_i;
            pend_v_q <= 1'b1;
         end
      end
   end

   // R5: an accepted edge restarts the second at zero
   p_ns_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_i |=> (acc_q == '0));
   // R6: the nanosecond field never reaches one billion
   p_ns_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_q < ACC_WRAP);
   // R7: the second of day stays inside the day
   p_sec_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_q < SOD_W'(SOD_PER_DAY));
   // R10: the offset only moves on an accepted edge
   p_off_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !accept_i |=> $stable(lock_off_o));
endmodule

// File: rtl/gts_legacy.sv
module gts_legacy #(
   parameter int CLK_HZ = 64_000_000,
   parameter int LEG_HZ = 12_000_000,
   parameter int W      = 48
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   output logic [W-1:0] cnt_o
);
   localparam int PH_W = $clog2(CLK_HZ + LEG_HZ) + 1;

   if (LEG_HZ == CLK_HZ) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) cnt_o <= '0;
         else         cnt_o <= cnt_o + 1'b1;
      end
   end else begin : g_frac
      logic [PH_W-1:0] ph_q, ph_sum_w;
      logic            carry_w;
      assign ph_sum_w = ph_q + PH_W'(LEG_HZ);
      assign carry_w  = ph_sum_w >= PH_W'(CLK_HZ);
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ph_q  <= '0;
            cnt_o <= '0;
         end else begin
            ph_q <= carry_w ? ph_sum_w - PH_W'(CLK_HZ) : ph_sum_w;
            if (carry_w) cnt_o <= cnt_o + 1'b1;
         end
      end
   end

   // R8: the legacy count moves by at most one per clock
   p_leg_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ##1 ((cnt_o - $past(cnt_o)) <= W'(1)));
endmodule

// File: rtl/gps_time_stamper.sv
module gps_time_stamper
   import gts_pkg::*;
#(
   parameter int CLK_HZ  = 64_000_000,
   parameter int LEG_HZ  = 12_000_000,
   parameter int TOL_DIV = 1000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pps_i,
   input  logic              gps_mode_i,
   input  logic              tod_valid_i,
   input  logic [SOD_W-1:0]  tod_sec_i,
   input  logic              frame_end_i,
   output logic [TS_W-1:0]   ts_o,
   output logic [TS_W-1:0]   stamp_o,
   output logic              stamp_vld_o,
   output logic [OFF_W-1:0]  lock_off_o
);
   localparam int   TOL       = CLK_HZ / TOL_DIV;
   localparam int   WIN_LO    = CLK_HZ - TOL;
   localparam int   WIN_HI    = CLK_HZ + TOL;
   localparam int   CNT_W     = $clog2(WIN_HI + 2) + 1;
   localparam acc_t INIT_STEP = ACC_WRAP / ACC_W'(CLK_HZ);

   if (CLK_HZ < 1000)                   begin : g_bad_clk $error("CLK_HZ too small"); end
   if (LEG_HZ < 1 || LEG_HZ > CLK_HZ)   begin : g_bad_leg $error("LEG_HZ out of range"); end
   if (TOL < 1)                         begin : g_bad_tol $error("TOL_DIV too large"); end

   logic             accept_w, measure_w, busy_w;
   logic [CNT_W-1:0] period_w;
   acc_t             step_w;
   ns_t              ns_w;
   sod_t             sec_w;
   logic [TS_W-1:0]  leg_w;

   gts_pps_gate #(.CNT_W(CNT_W), .LO(WIN_LO), .HI(WIN_HI)) u_gate (
      .clk_i, .rst_ni, .pps_i,
      .accept_o(accept_w), .measure_o(measure_w), .period_o(period_w));

   gts_step_div #(.DEN_W(CNT_W), .Q_W(ACC_W), .NUM(ACC_WRAP), .INIT(INIT_STEP)) u_div (
      .clk_i, .rst_ni, .start_i(measure_w), .den_i(period_w),
      .busy_o(busy_w), .step_o(step_w));

   gts_ns_core u_core (
      .clk_i, .rst_ni, .accept_i(accept_w), .step_i(step_w),
      .tod_valid_i, .tod_sec_i, .ns_o(ns_w), .sec_o(sec_w), .lock_off_o);

   gts_legacy #(.CLK_HZ(CLK_HZ), .LEG_HZ(LEG_HZ), .W(TS_W)) u_leg (
      .clk_i, .rst_ni, .cnt_o(leg_w));

   assign ts_o = gps_mode_i ? {sec_w, ns_w} : leg_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stamp_o     <= '0;
         stamp_vld_o <= 1'b0;
      end else begin
         stamp_vld_o <= frame_end_i;
         if (frame_end_i) stamp_o <= ts_o;
      end
   end

   // R9: a frame end yields one capture of the value current at the strobe
   p_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_end_i |=> (stamp_vld_o && stamp_o == $past(ts_o)));
   p_no_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_end_i |=> (!stamp_vld_o && $stable(stamp_o)));
   // R3: a period measurement arrives only when the divider is idle
   p_measure_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      measure_w |-> !busy_w);
endmodule

// File: tb/gps_time_stamper_tb.sv
module gps_time_stamper_tb;
   localparam int CLK_HZ = 4000;
   localparam int LEG_HZ = 750;
   localparam int LO = 3996;
   localparam int HI = 4004;
   localparam int DIV_LAT = 62;
   localparam longint unsigned ONE_S = 64'd1000000000;
   localparam longint unsigned CWRAP = 64'd1000000000 << 32;

   logic        clk = 0, rst_n = 0;
   logic        pps = 0, mode = 1, tod_v = 0, fend = 0;
   logic [17:0] tod = '0;
   logic [47:0] ts, stamp;
   logic        svld;
   logic [31:0] loff;

   gps_time_stamper #(.CLK_HZ(CLK_HZ), .LEG_HZ(LEG_HZ), .TOL_DIV(1000)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .pps_i(pps), .gps_mode_i(mode),
      .tod_valid_i(tod_v), .tod_sec_i(tod), .frame_end_i(fend),
      .ts_o(ts), .stamp_o(stamp), .stamp_vld_o(svld), .lock_off_o(loff));

   always #10 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input longint unsigned act,
                        input longint unsigned exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   longint unsigned acc_m, step_m, nstep_m, leg_m;
   longint unsigned stamp_m;
   int  cnt_m, sec_m, pend_m, n_m, sched_m, lock_m;
   bit  ref_m, pend_v_m, sched_v_m, vld_m, p1, p2, p3;
   string evt = "";

   function automatic int sec_next(input int s);
      return (s == 86399) ? 0 : s + 1;
   endfunction

   function automatic longint unsigned model_ts();
      longint unsigned nsv = acc_m >> 32;
      if (mode) return (longint'(sec_m) << 30) | nsv;
      return leg_m;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         acc_m = 0; step_m = CWRAP / CLK_HZ; leg_m = 0; stamp_m = 0;
         cnt_m = 0; sec_m = 0; pend_m = 0; n_m = 0; lock_m = 0;
         ref_m = 0; pend_v_m = 0; sched_v_m = 0; vld_m = 0; p1 = 0; p2 = 0; p3 = 0;
      end else begin
         longint unsigned cur_ts, nsv;
         bit rise, acc_ok;
         n_m++;
         cur_ts = model_ts();
         nsv = acc_m >> 32;
         rise = p2 && !p3;
         p3 = p2; p2 = p1; p1 = pps;
         acc_ok = rise && (!ref_m || (cnt_m >= LO && cnt_m <= HI));
         if (rise && !acc_ok) evt = "R4 rejected edge";
         if (acc_ok) begin
            lock_m = (nsv >= 500000000) ? int'(nsv) - int'(ONE_S) : int'(nsv);
            if (pend_v_m) sec_m = pend_m;
            else if (nsv >= 500000000) sec_m = sec_next(sec_m);
            evt = ref_m ? "R5 R10 accepted edge" : "R11 R5 alignment edge";
            acc_m = 0;
            if (ref_m) begin
               nstep_m = CWRAP / longint'(cnt_m);
               sched_m = n_m + DIV_LAT; sched_v_m = 1;
            end
            cnt_m = 1; ref_m = 1; pend_v_m = 0;
         end else begin
            acc_m += step_m;
            if (acc_m >= CWRAP) begin
               acc_m -= CWRAP;
               evt = (sec_m == 86399) ? "R7 day wrap" : "R6 free wrap";
               sec_m = sec_next(sec_m);
            end
            if (ref_m && cnt_m > HI) ref_m = 0;
            cnt_m++;
         end
         if (tod_v && tod < 86400) begin pend_m = tod; pend_v_m = 1; end
         if (sched_v_m && n_m == sched_m) begin
            step_m = nstep_m; sched_v_m = 0; evt = "R3 step load";
         end
         leg_m = (longint'(n_m) * LEG_HZ) / CLK_HZ;
         vld_m = fend;
         if (fend) stamp_m = cur_ts;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            check(ts == 0 && stamp == 0 && !svld && loff == 0, "R1 reset", ts, 0);
         end else begin
            check(ts == model_ts(), mode ? "R2 R8 gps word" : "R8 legacy", ts, model_ts());
            check(stamp == stamp_m[47:0] && svld == vld_m, "R9 stamp", stamp, stamp_m);
            check(loff == 32'(lock_m), "R10 offset", loff, 32'(lock_m));
            if (evt != "") begin
               check(ts == model_ts() && loff == 32'(lock_m), evt, ts, model_ts());
               evt = "";
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic gap_pulse(input int gap);
      tick(gap - 3);
      pps = 1; tick(3); pps = 0;
   endtask

   task automatic send_tod(input int s);
      tod = 18'(s); tod_v = 1; tick(1); tod_v = 0;
   endtask

   initial begin : frames
      wait (rst_n);
      while (!done) begin
         tick(36); fend = 1; tick(1); fend = 0;
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      tick(3);
      rst_n = 1;
      tick(20);
      send_tod(100);                       // R5 pending load
      gap_pulse(300);                       // R11 first edge aligns only
      gap_pulse(4002);                      // R3 R4 in-window edge
      gap_pulse(1000);                      // R4 glitch rejected
      gap_pulse(3000);                      // 4000 after accepted edge
      gap_pulse(3990);                      // R4 out-of-window
      gap_pulse(10);                        // 4000 after accepted edge
      tick(500);
      send_tod(86399);
      send_tod(90000);                      // R5 ignored value
      gap_pulse(3997 - 500 - 2);
      mode = 0; tick(300); mode = 1;        // R8 legacy view
      tick(9000);                           // R6 R7 free run, R11 ref lost
      gap_pulse(2500);                      // R11 realign
      gap_pulse(3996);
      gap_pulse(4004);                      // counter wraps early, R5 hold
      gap_pulse(4000);
      tick(200);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule